// File: doc/BRIEF.md
# DS2 Transmit Multiplexer for Four DS1 Tributaries

This block builds a serial DS2 stream from four DS1 tributaries on the transmit side. It takes one bit per clock from the tributary selected by the current time slot. It interleaves the tributaries bit by bit and inserts the DS2 overhead: multiframe alignment, frame alignment and stuff-control bits. When a tributary requests it, the block replaces one data slot with a stuff bit. Tributaries two and four are logically inverted on their way into the stream.

The upstream elastic stores are outside the block. A per-tributary read strobe tells them when a bit has been taken, and a stuff-request bit per tributary tells the block when to stuff. A control input can signal a loopback request to the far end. It does this by inverting the stuff-control bits of one chosen tributary. The E1-carrying variant of DS2 is not built. Selecting it raises an error flag and forces the line to all ones.

The multiframe has four subframes. Each subframe has six blocks, and each block is one overhead bit followed by `INFO_BITS` information bits. With the default of 48 this gives 1176 bits per multiframe.

Top module: `ds2_m12_tx`

## Requirements
- R1: Information slot k of a block (k = 1..INFO_BITS) carries tributary ((k-1) mod 4)+1. Tributaries 1 and 3 pass unchanged and tributaries 2 and 4 are inverted.
- R2: Within every subframe the overhead bits of blocks 1..6 are M, C, F0, C, C, F1, with F0 = 0 and F1 = 1.
- R3: The M bits of subframes 1, 2, 3 and 4 are 0, 1, 1 and the value of `x_bit`.
- R4: If `stuff_req[i-1]` is high at the first bit of subframe i, all three C bits of that subframe are 1. The first slot of tributary i in block 6 then carries a stuff bit of value 0 and no data. Otherwise the C bits are 0 and that slot carries data.
- R5: When `lb_en` is high and `lb_trib` (0..3 selecting tributaries 1..4) names subframe i's tributary, the three C bits of that subframe are inverted. This happens only if no stuff occurs in that subframe.
- R6: `trib_rd` has exactly bit t-1 high in the cycle in which tributary t's `trib_data` bit is consumed, and is zero otherwise. This gives 6*INFO_BITS strobes per tributary per multiframe, minus one if that tributary is stuffed.
- R7: Every output bit appears on `ds2_data` one clock after its slot is selected. `frame_start` is high with the first M bit, and a synchronous reset restarts at subframe 1, block 1.
- R8: While `e1_mode` is high, `mode_err` is 1 one cycle later. From then on `ds2_data` is 1, `frame_start` is 0 and no strobe fires.
- R9: During reset `ds2_data`, `frame_start`, `mode_err` and `trib_rd` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock, one DS2 bit per cycle |
| rst | input | 1 | Synchronous reset, active high |
| trib_data | input | 4 | Current bit of each DS1 tributary |
| stuff_req | input | 4 | Stuff request per tributary |
| lb_en | input | 1 | Enable loopback-request signalling |
| lb_trib | input | 2 | Tributary addressed by the loopback request |
| x_bit | input | 1 | Value of the fourth M bit |
| e1_mode | input | 1 | Selects the unsupported E1 variant |
| ds2_data | output | 1 | Serial DS2 output |
| frame_start | output | 1 | Marks the first M bit |
| trib_rd | output | 4 | Per-tributary read strobe |
| mode_err | output | 1 | Unsupported mode selected |

## Verification
The bench builds the block with `INFO_BITS` = 8. This shrinks the multiframe to 216 bits, so several complete multiframes fit in each scenario. Every subframe's stuff slot, C-bit group and M bit is compared bit for bit many times. The short blocks also make the interleave order and the inversion of tributaries two and four visible within a handful of cycles. Strobe totals are counted over a full multiframe.

// File: rtl/ds2_m12_tx.sv
module ds2_m12_tx #(
  parameter int INFO_BITS = 48  // information bits per block, multiple of 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] trib_data,
  input  logic [3:0] stuff_req,
  input  logic       lb_en,
  input  logic [1:0] lb_trib,
  input  logic       x_bit,
  input  logic       e1_mode,
  output logic       ds2_data,
  output logic       frame_start,
  output logic [3:0] trib_rd,
  output logic       mode_err
);
  localparam int SLOTS = INFO_BITS + 1;
  localparam int PW = $clog2(SLOTS);
  localparam logic [3:0] INV = 4'b1010;

  logic [1:0]    sf;
  logic [2:0]    blk;
  logic [PW-1:0] pos;
  logic          st_lat, lb_lat;

  wire           is_ovh   = (pos == '0);
  wire           last_pos = (pos == PW'(INFO_BITS));
  wire           at_m     = is_ovh && (blk == 3'd0);
  wire [PW-1:0]  ipos     = pos - PW'(1);
  wire [1:0]     tsel     = ipos[1:0];
  wire           stuff_slot = (blk == 3'd5) && !is_ovh && (ipos == PW'(sf)) && st_lat;
  wire           c_bit    = st_lat ^ lb_lat;

  logic m_bit, ovh_bit, nxt_bit;

  always_comb begin
    case (sf)
      2'd0:    m_bit = 1'b0;
      2'd1:    m_bit = 1'b1;
      2'd2:    m_bit = 1'b1;
      default: m_bit = x_bit;
    endcase
    case (blk)
      3'd0:    ovh_bit = m_bit;
      3'd2:    ovh_bit = 1'b0;
      3'd5:    ovh_bit = 1'b1;
      default: ovh_bit = c_bit;
    endcase
    if (is_ovh)          nxt_bit = ovh_bit;
    else if (stuff_slot) nxt_bit = 1'b0;
    else                 nxt_bit = trib_data[tsel] ^ INV[tsel];
  end

  assign trib_rd = (!is_ovh && !stuff_slot && !mode_err) ? (4'b0001 << tsel) : 4'b0000;

  always_ff @(posedge clk) begin
    if (rst) begin
      sf <= '0; blk <= '0; pos <= '0;
      st_lat <= 1'b0; lb_lat <= 1'b0;
      ds2_data <= 1'b0; frame_start <= 1'b0; mode_err <= 1'b0;
    end else begin
      mode_err    <= e1_mode;
      ds2_data    <= mode_err ? 1'b1 : nxt_bit;
      frame_start <= !mode_err && at_m && (sf == 2'd0);
      if (at_m) begin
        st_lat <= stuff_req[sf];
        lb_lat <= lb_en && (lb_trib == sf) && !stuff_req[sf];
      end
      if (last_pos) begin
        pos <= '0;
        if (blk == 3'd5) begin
          blk <= '0;
          sf  <= sf + 2'd1;
        end else begin
          blk <= blk + 3'd1;
        end
      end else begin
        pos <= pos + PW'(1);
      end
    end
  end

  // R6
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(trib_rd));
  // R8
  mode_quiet_chk: assert property (@(posedge clk) disable iff (rst) mode_err |-> (trib_rd == 4'b0000));
  // R7
  fs_mbit_chk: assert property (@(posedge clk) disable iff (rst) frame_start |-> !ds2_data);
  // R4
  stuff_hold_chk: assert property (@(posedge clk) disable iff (rst) !at_m |=> $stable(st_lat));
  // R2
  blk_range_chk: assert property (@(posedge clk) disable iff (rst) blk < 3'd6);
endmodule

// File: tb/ds2_m12_tx_tb.sv
module ds2_m12_tx_tb_top;
  localparam int INFO = 8;
  localparam int B = INFO + 1;
  localparam int MF = 24 * B;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] trib_data = '0, stuff_req = '0;
  logic lb_en = 1'b0, x_bit = 1'b0, e1_mode = 1'b0;
  logic [1:0] lb_trib = '0;
  logic ds2_data, frame_start, mode_err;
  logic [3:0] trib_rd;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  ds2_m12_tx #(.INFO_BITS(INFO)) dut_i (
    .clk(clk), .rst(rst), .trib_data(trib_data), .stuff_req(stuff_req),
    .lb_en(lb_en), .lb_trib(lb_trib), .x_bit(x_bit), .e1_mode(e1_mode),
    .ds2_data(ds2_data), .frame_start(frame_start), .trib_rd(trib_rd),
    .mode_err(mode_err));

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_bit(input int s);
    int r, sf, blk, pos, t;
    logic st, lb;
    r = s % MF; sf = r / (6 * B); blk = (r % (6 * B)) / B; pos = r % B;
    st = stuff_req[sf];
    lb = lb_en && (int'(lb_trib) == sf) && !st;
    if (pos == 0) begin
      case (blk)
        0: return (sf == 0) ? 1'b0 : (sf == 3) ? x_bit : 1'b1;
        2: return 1'b0;
        5: return 1'b1;
        default: return st ^ lb;
      endcase
    end
    t = (pos - 1) % 4;
    if (blk == 5 && pos - 1 == sf && st) return 1'b0;
    return trib_data[t] ^ ((t == 1) || (t == 3));
  endfunction

  function automatic logic [3:0] exp_rd(input int s);
    int r, sf, blk, pos;
    r = s % MF; sf = r / (6 * B); blk = (r % (6 * B)) / B; pos = r % B;
    if (pos == 0) return 4'b0;
    if (blk == 5 && pos - 1 == sf && stuff_req[sf]) return 4'b0;
    return 4'b0001 << ((pos - 1) % 4);
  endfunction

  task automatic do_reset;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_check(input string req, input int n);
    for (int s = 0; s < n; s++) begin
      @(negedge clk);
      chk(req, {3'b0, ds2_data}, {3'b0, exp_bit(s)});
      chk("R7", {3'b0, frame_start}, {3'b0, (s % MF) == 0});
      chk("R6", trib_rd, exp_rd(s + 1));
    end
  endtask

  task automatic t_reset_state;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 ds2", {3'b0, ds2_data}, 4'b0);
    chk("R9 fs", {3'b0, frame_start}, 4'b0);
    chk("R9 err", {3'b0, mode_err}, 4'b0);
    chk("R9 rd", trib_rd, 4'b0);
    rst = 1'b0;
  endtask

  task automatic t_plain;
    trib_data = 4'b0000; stuff_req = 4'b0; lb_en = 0; x_bit = 0;
    do_reset; run_check("R1 R2 R3 zeros", 2 * MF);
    trib_data = 4'b1111; x_bit = 1;
    do_reset; run_check("R1 R3 ones x=1", 2 * MF);
    trib_data = 4'b0110;
    do_reset; run_check("R1 mixed", MF);
  endtask

  task automatic t_stuff;
    trib_data = 4'b0101; stuff_req = 4'b1001; x_bit = 0;
    do_reset; run_check("R4 stuff 1,4", 2 * MF);
    stuff_req = 4'b0110; trib_data = 4'b1010;
    do_reset; run_check("R4 stuff 2,3", MF);
    stuff_req = 4'b0;
  endtask

  task automatic t_loop;
    trib_data = 4'b0011; stuff_req = 4'b0; lb_en = 1; lb_trib = 2'd2;
    do_reset; run_check("R5 loopback trib3", 2 * MF);
    stuff_req = 4'b0100;
    do_reset; run_check("R5 loopback suppressed by stuff", MF);
    lb_trib = 2'd0; stuff_req = 4'b0010;
    do_reset; run_check("R5 loopback trib1 with stuff on 2", MF);
    lb_en = 0; stuff_req = 4'b0;
  endtask

  task automatic t_strobe_count;
    int cnt[4];
    trib_data = 4'b1100; stuff_req = 4'b1010;
    do_reset;
    for (int i = 0; i < 4; i++) cnt[i] = 0;
    for (int s = 0; s < MF; s++) begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) cnt[i] += int'(trib_rd[i]);
    end
    for (int i = 0; i < 4; i++) begin
      checks++;
      if (cnt[i] != 6 * INFO - int'(stuff_req[i])) begin
        errors++;
        $display("FAIL R6 count trib%0d actual=%0d expected=%0d", i + 1, cnt[i], 6 * INFO - int'(stuff_req[i]));
      end
    end
    stuff_req = 4'b0;
  endtask

  task automatic t_e1;
    trib_data = 4'b0000;
    do_reset;
    e1_mode = 1'b1;
    repeat (3) @(negedge clk);
    for (int s = 0; s < MF; s++) begin
      chk("R8 err", {3'b0, mode_err}, 4'b0001);
      chk("R8 ds2", {3'b0, ds2_data}, 4'b0001);
      chk("R8 fs", {3'b0, frame_start}, 4'b0);
      chk("R8 rd", trib_rd, 4'b0);
      @(negedge clk);
    end
    e1_mode = 1'b0;
    do_reset; run_check("R8 recovery", MF);
  endtask

  task automatic t_midreset;
    trib_data = 4'b1001; stuff_req = 4'b0100; x_bit = 1;
    do_reset;
    repeat (137) @(negedge clk);
    do_reset; run_check("R7 restart", MF + 20);
    stuff_req = 4'b0;
  endtask

  initial begin
    t_reset_state;
    t_plain;
    t_stuff;
    t_loop;
    t_strobe_count;
    t_e1;
    t_midreset;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule